// File: doc/BRIEF.md
# IR Transmit Length Timer

This block drives an infrared transmit pin. Software chooses a data bit and a segment length. While the block runs in transmit mode, the pin carries a square-wave carrier when the data bit is 1 and stays low when it is 0. An 8-bit down counter times each segment. It is clocked by a tick taken from a power-of-two prescaler on the peripheral clock. When the counter steps below zero it raises a sticky interrupt flag, so that software can supply the next bit and length.

The carrier comes from its own divider, which has separate high and low phase lengths. The tick prescaler has its own 4-bit select. Configuration inputs (tick select, carrier phases, interrupt enable) are meant to change only while `enable` is 0. Before enabling, software should clear the data bit and load a length of 0.

The length counter FSM has two states. LC_OFF goes to LC_RUN when transmit operation becomes active, and the counter loads on that transition. LC_RUN goes back to LC_OFF when it becomes inactive. The carrier FSM has three states. CR_OFF goes to CR_HIGH on activation. CR_HIGH goes to CR_LOW after `car_high`+1 cycles, and CR_LOW goes back to CR_HIGH after `car_low`+1 cycles. Any state goes to CR_OFF on deactivation.

Top module: `ir_tx_timer`

## Requirements
- R1: With `tick_sel` = n (0 to 14), a tick occurs on every 2^n-th cycle of active operation. Active cycles are counted from 1 at activation, and for n = 0 every cycle ticks.
- R2: Activation means `enable`=1 and `rx_mode`=0. In the first active cycle the counter loads the stored length. After that it falls by one on each tick and holds its value between ticks.
- R3: A tick while the counter is 0 is an underflow. On an underflow the counter reloads from the stored length, so a length L lasts L+1 ticks.
- R4: An underflow sets `irq_flag`. The flag stays set until a cycle with `irq_clr`=1, and an underflow in that same cycle wins, leaving the flag set.
- R5: `ir_out` equals the carrier while active and `data_bit`=1. Otherwise `ir_out` is 0, which includes `rx_mode`=1 and `enable`=0.
- R6: The carrier goes high in the cycle after activation. It then stays high for `car_high`+1 cycles and low for `car_low`+1 cycles, and repeats.
- R7: `tick_sel` = 4'hF produces no ticks, so the counter stays frozen while running.
- R8: A `len_wr` pulse stores `len_val`. If the block is running, the next tick reloads the counter with the stored value and does not count as an underflow.
- R9: `irq` equals `irq_flag` AND `irq_en`.
- R10: While inactive, `cnt_val` reads 0 and the prescaler phase restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Run enable |
| rx_mode | input | 1 | Mode select, 0 = transmit |
| tick_sel | input | 4 | Length tick divider code |
| car_high | input | 8 | Carrier high phase length minus one |
| car_low | input | 8 | Carrier low phase length minus one |
| data_bit | input | 1 | Current data bit |
| len_wr | input | 1 | Length write strobe |
| len_val | input | 8 | Length value to store |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Flag clear strobe |
| ir_out | output | 1 | Modulated transmit output |
| irq | output | 1 | Interrupt request |
| irq_flag | output | 1 | Sticky underflow flag |
| cnt_val | output | 8 | Current length counter value |

## Verification
Two functions can act on the same cycle. One is an underflow that sets the flag while `irq_clr` is asserted. The other is a tick that would underflow while a length reload is pending. The bench holds `irq_clr` high across several short segments with tick code 0, and it writes new lengths while segments are running. A behavioural model predicts every cycle, with the rule that the underflow wins over the clear and the reload wins over the underflow. The model's `irq_flag`, `irq` and `cnt_val` are compared with the design on each clock.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

    typedef enum logic [0:0] {
        LC_OFF = 1'b0,
        LC_RUN = 1'b1
    } lc_state_t;

    typedef enum logic [1:0] {
        CR_OFF  = 2'd0,
        CR_HIGH = 2'd1,
        CR_LOW  = 2'd2
    } cr_state_t;

endpackage

// File: rtl/ir_tick_prescaler.sv
module ir_tick_prescaler #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NCODES = 1 << SEL_W;
    localparam int DIV_W  = NCODES - 2;

    logic [DIV_W-1:0]  div_q;
    logic [NCODES-1:0] hit;

    // Free-running phase counter, restarted whenever operation stops
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (!active) div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end

    // One match term per code; the top code is reserved and never matches
    for (genvar k = 0; k < NCODES; k++) begin : g_hit
        if (k == 0) begin : g_every
            assign hit[k] = 1'b1;
        end else if (k == NCODES - 1) begin : g_rsv
            assign hit[k] = 1'b0;
        end else begin : g_pow
            assign hit[k] = &div_q[k-1:0];
        end
    end

    assign tick = active & hit[sel];

endmodule

// File: rtl/ir_len_counter.sv
module ir_len_counter
    import ir_tx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_val,
    input  logic             irq_clr,
    output logic [LEN_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             running_o
);
    lc_state_t        state_q, state_d;
    logic [LEN_W-1:0] len_q, cnt_q;
    logic             pend_q, flag_q;
    logic             underflow;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LC_OFF:  if (active)  state_d = LC_RUN;
            LC_RUN:  if (!active) state_d = LC_OFF;
            default: state_d = LC_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LC_OFF;
        else        state_q <= state_d;
    end

    assign underflow = (state_q == LC_RUN) && active && tick && !pend_q
                       && (cnt_q == '0);

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (len_wr) len_q <= len_val;
            if (!active) begin
                cnt_q  <= '0;
                pend_q <= 1'b0;
            end else if (state_q == LC_OFF) begin
                cnt_q  <= len_q;
                pend_q <= len_wr;
            end else begin
                if (tick) begin
                    if (pend_q || cnt_q == '0) cnt_q <= len_q;
                    else                       cnt_q <= cnt_q - 1'b1;
                end
                pend_q <= len_wr | (pend_q & ~tick);
            end
            flag_q <= underflow | (flag_q & ~irq_clr);
        end
    end

    assign cnt_o     = cnt_q;
    assign flag_o    = flag_q;
    assign running_o = (state_q == LC_RUN);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && active && !tick) |=> $stable(cnt_o));
    // R3
    uflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (cnt_o == $past(len_q)));
    // R4
    uflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> flag_o);
    // R10
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_o == '0));

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ir_tx_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [CW-1:0] hi_len,
    input  logic [CW-1:0] lo_len,
    output logic          high_o
);
    cr_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CR_OFF:  if (active) state_d = CR_HIGH;
            CR_HIGH: begin
                if (!active)              state_d = CR_OFF;
                else if (cnt_q == hi_len) state_d = CR_LOW;
            end
            CR_LOW: begin
                if (!active)              state_d = CR_OFF;
                else if (cnt_q == lo_len) state_d = CR_HIGH;
            end
            default: state_d = CR_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CR_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       cnt_q <= '0;
        else if (state_d == state_q && state_q != CR_OFF) cnt_q <= cnt_q + 1'b1;
        else                                              cnt_q <= '0;
    end

    assign high_o = (state_q == CR_HIGH);

    // R6
    phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n || !active)
        (state_q == CR_HIGH) |-> (cnt_q <= hi_len));

endmodule

// File: rtl/ir_tx_timer.sv
module ir_tx_timer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       rx_mode,
    input  logic [3:0] tick_sel,
    input  logic [7:0] car_high,
    input  logic [7:0] car_low,
    input  logic       data_bit,
    input  logic       len_wr,
    input  logic [7:0] len_val,
    input  logic       irq_en,
    input  logic       irq_clr,
    output logic       ir_out,
    output logic       irq,
    output logic       irq_flag,
    output logic [7:0] cnt_val
);
    localparam int SEL_W = 4;
    localparam int LEN_W = 8;
    localparam int CW    = 8;

    logic active, tick, car_on, flag, running;

    assign active = enable & ~rx_mode;

    ir_tick_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .active(active), .sel(tick_sel), .tick(tick)
    );

    ir_len_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .active(active), .tick(tick),
        .len_wr(len_wr), .len_val(len_val), .irq_clr(irq_clr),
        .cnt_o(cnt_val), .flag_o(flag), .running_o(running)
    );

    ir_carrier_gen #(.CW(CW)) u_car (
        .clk(clk), .rst_n(rst_n), .active(active),
        .hi_len(car_high), .lo_len(car_low), .high_o(car_on)
    );

    assign ir_out   = active & car_on & data_bit;
    assign irq_flag = flag;
    assign irq      = flag & irq_en;

    // R7
    rsv_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n || !active)
        ((&tick_sel) && running) |=> $stable(cnt_val));

endmodule

// File: tb/sim_ir_tx_timer.sv
module sim_ir_tx_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 0, rx_mode = 0, data_bit = 0, len_wr = 0, irq_en = 0, irq_clr = 0;
    logic [3:0] tick_sel = 0;
    logic [7:0] car_high = 0, car_low = 0, len_val = 0;
    logic       ir_out, irq, irq_flag;
    logic [7:0] cnt_val;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_tx_timer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rx_mode(rx_mode),
        .tick_sel(tick_sel), .car_high(car_high), .car_low(car_low),
        .data_bit(data_bit), .len_wr(len_wr), .len_val(len_val),
        .irq_en(irq_en), .irq_clr(irq_clr), .ir_out(ir_out), .irq(irq),
        .irq_flag(irq_flag), .cnt_val(cnt_val)
    );

    // Behavioural reference model
    int m_div = 0, m_len = 0, m_cnt = 0, m_ph = 0, m_cc = 0;
    bit m_run = 0, m_pend = 0, m_flag = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_len = 0; m_cnt = 0; m_ph = 0; m_cc = 0;
            m_run = 0; m_pend = 0; m_flag = 0;
        end else begin
            bit act, tk, setf, n_run, n_pend;
            int n_cnt, p;
            act = enable && !rx_mode;
            tk = 0;
            if (act && tick_sel != 4'hF) begin
                p = 1 << tick_sel;
                tk = ((m_div % p) == p - 1);
            end
            n_run = m_run; n_pend = m_pend; n_cnt = m_cnt; setf = 0;
            if (!act) begin
                n_run = 0; n_cnt = 0; n_pend = 0;
            end else if (!m_run) begin
                n_run = 1; n_cnt = m_len; n_pend = len_wr;
            end else begin
                if (tk) begin
                    if (m_pend) begin n_cnt = m_len; n_pend = 0; end
                    else if (m_cnt == 0) begin n_cnt = m_len; setf = 1; end
                    else n_cnt = m_cnt - 1;
                end
                if (len_wr) n_pend = 1;
            end
            if (setf) m_flag = 1;
            else if (irq_clr) m_flag = 0;
            m_run = n_run; m_pend = n_pend; m_cnt = n_cnt;
            m_div = act ? (m_div + 1) % 16384 : 0;
            if (len_wr) m_len = len_val;
            if (!act) begin
                m_ph = 0; m_cc = 0;
            end else if (m_ph == 0) begin
                m_ph = 1; m_cc = 0;
            end else if (m_ph == 1) begin
                if (m_cc == car_high) begin m_ph = 2; m_cc = 0; end else m_cc++;
            end else begin
                if (m_cc == car_low) begin m_ph = 1; m_cc = 0; end else m_cc++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            int e_out;
            e_out = (enable && !rx_mode && m_ph == 1 && data_bit) ? 1 : 0;
            chk(ir_out == e_out[0], "R5/R6 ir_out", ir_out, e_out);
            chk(cnt_val == m_cnt[7:0], "R1/R2/R3/R8/R10 cnt_val", cnt_val, m_cnt);
            chk(irq_flag == m_flag, "R4 irq_flag", irq_flag, m_flag);
            chk(irq == (m_flag && irq_en), "R9 irq", irq, m_flag && irq_en);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic write_len(input int v);
        len_wr = 1; len_val = v[7:0];
        cyc(1);
        len_wr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        // Reset state (R2, R4, R5)
        chk(cnt_val == 0, "R2 reset cnt", cnt_val, 0);
        chk(irq_flag == 0, "R4 reset flag", irq_flag, 0);
        chk(ir_out == 0, "R5 reset out", ir_out, 0);
        rst_n = 1;
        cyc(2);

        // R1 R2 R3 R6: code 0, length 3, data toggling
        car_high = 1; car_low = 2; irq_en = 1; tick_sel = 0;
        write_len(3);
        data_bit = 1; enable = 1;
        cyc(20);
        data_bit = 0; cyc(7);
        data_bit = 1; cyc(9);

        // R4 R9: clear after stopping, flag must drop
        enable = 0; cyc(2);
        irq_clr = 1; cyc(1); irq_clr = 0;
        chk(irq_flag == 0, "R4 flag cleared", irq_flag, 0);
        chk(irq == 0, "R9 irq low after clear", irq, 0);

        // R1: code 2, different carrier
        tick_sel = 2; car_high = 3; car_low = 0;
        write_len(2);
        enable = 1; cyc(60);

        // R8: rewrite while running
        write_len(5); cyc(30);
        write_len(1); cyc(25);

        // R4: set/clear collision with code 0
        enable = 0; cyc(1);
        tick_sel = 0; write_len(2);
        enable = 1; cyc(2);
        irq_clr = 1; cyc(9); irq_clr = 0;
        cyc(4);

        // R9: interrupt masked
        irq_en = 0; cyc(10);
        irq_en = 1; cyc(2);

        // R7: reserved code freezes counter
        enable = 0; cyc(1);
        tick_sel = 4'hF; write_len(4);
        enable = 1; cyc(20);
        chk(cnt_val == 4, "R7 frozen count", cnt_val, 4);

        // R5: receive mode keeps output low
        rx_mode = 1; cyc(10);
        chk(ir_out == 0, "R5 rx mode out", ir_out, 0);
        chk(cnt_val == 0, "R10 inactive count", cnt_val, 0);
        rx_mode = 0;

        // R1: code 3 and code 14
        enable = 0; cyc(1);
        tick_sel = 3; write_len(1);
        enable = 1; cyc(70);
        enable = 0; cyc(1);
        tick_sel = 14; enable = 1; cyc(100);
        enable = 0; cyc(3);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule